// File: doc/BRIEF.md
# Operand Select and ALU Execute Stage

This block is the combinational execute stage of a 16-bit processor. It takes the instruction word and splits out its register-index fields. It picks the second operand: either the second register-file read value or a small signed constant held in the instruction. It then applies one of four functions, chosen by a 2-bit function code from the control unit.

The result goes onto a shared internal bus. A one-bit enable controls this: while the enable is low the block drives all zeros, so several sources can be OR-ed onto the bus. Memory stores use the pass-through function to carry the store-source register value toward the memory data register. Addition wraps modulo 2^16 and produces no carry or overflow flag.

Top module: `exec_alu`

## Requirements
- R1: With func = 00 the result is operand A plus operand B, truncated to 16 bits (wraps, no carry output).
- R2: With func = 11 the result is the bitwise AND of operand A and operand B.
- R3: With func = 10 the result is the bitwise complement of operand A, and operand B has no effect.
- R4: With func = 01 the result equals operand A unchanged, and operand B has no effect. Stores use this path to forward their source register.
- R5: When instr[5] = 1, operand B is instr[4:0] sign-extended to 16 bits (for example 11111 gives 0xFFFF and 10000 gives 0xFFF0), and rd_b is ignored.
- R6: When instr[5] = 0, operand B is rd_b, and instr[4:3] have no effect.
- R7: dst_idx equals instr[11:9], src1_idx equals instr[8:6] and src2_idx equals instr[2:0], whatever the opcode.
- R8: When bus_en = 0, result is all zeros; when bus_en = 1, result carries the function output.
- R9: Full encodings behave as expected with the matching function code: add is opcode 0001, and is 0101 and complement is 1001 with instr[5:0] = 111111, each in instr[15:12].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word |
| rd_a | input | 16 | First register-file read value (operand A) |
| rd_b | input | 16 | Second register-file read value |
| func | input | 2 | Function code: 00 add, 01 pass A, 10 complement A, 11 AND |
| bus_en | input | 1 | Drives the result onto the shared bus |
| result | output | 16 | Function output, or zero when not enabled |
| dst_idx | output | 3 | Destination register index |
| src1_idx | output | 3 | First source register index |
| src2_idx | output | 3 | Second source register index |

## Verification
The block holds no state, so any fault in operand selection or function decode shows up on result during the same evaluation as the stimulus that exposes it. A wrong immediate sign extension appears only for negative constants. A swapped select appears only when rd_b and the immediate differ. A wrong enable shows up as a non-zero result while disabled. The stimulus therefore covers both immediate signs, register values that differ from the constant, and both enable levels.

// File: rtl/exec_alu.sv
module exec_alu #(
  parameter int W    = 16,
  parameter int IMMW = 5,
  parameter int IDXW = 3
) (
  input  logic [W-1:0]    instr,
  input  logic [W-1:0]    rd_a,
  input  logic [W-1:0]    rd_b,
  input  logic [1:0]      func,
  input  logic            bus_en,
  output logic [W-1:0]    result,
  output logic [IDXW-1:0] dst_idx,
  output logic [IDXW-1:0] src1_idx,
  output logic [IDXW-1:0] src2_idx
);
  localparam int DST_LO = 9;
  localparam int SR1_LO = 6;
  localparam int SEL_BIT = IMMW;

  logic [W-1:0] imm_ext, opb, fout;

  assign dst_idx  = instr[DST_LO +: IDXW];
  assign src1_idx = instr[SR1_LO +: IDXW];
  assign src2_idx = instr[0 +: IDXW];

  assign imm_ext = {{(W-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};
  assign opb     = instr[SEL_BIT] ? imm_ext : rd_b;

  always_comb begin
    case (func)
      2'b00:   fout = rd_a + opb;
      2'b01:   fout = rd_a;
      2'b10:   fout = ~rd_a;
      default: fout = rd_a & opb;
    endcase
  end

  assign result = bus_en ? fout : '0;

  always_comb begin
    if (!bus_en)
      assert_bus_idle_R8: assert (result == '0);
    if (bus_en && func == 2'b01)
      assert_pass_a_R4: assert (result == rd_a);
    if (bus_en && func == 2'b10)
      assert_compl_R3: assert ((result ^ rd_a) == '1);
    if (bus_en && func == 2'b00 && instr[SEL_BIT])
      assert_imm_add_R5: assert (W'(result - rd_a) == imm_ext);
    if (bus_en && func == 2'b11 && !instr[SEL_BIT])
      assert_reg_and_R6: assert ((result & ~rd_b) == '0);
  end
endmodule

// File: tb/tb_exec_alu.sv
module tb_exec_alu;
  logic clk = 0;
  always #5 clk = ~clk;

  logic [15:0] instr, rd_a, rd_b, result;
  logic [1:0]  func;
  logic        bus_en;
  logic [2:0]  dst_idx, src1_idx, src2_idx;
  int total = 0, bad = 0;

  exec_alu dut (.instr(instr), .rd_a(rd_a), .rd_b(rd_b), .func(func), .bus_en(bus_en),
                .result(result), .dst_idx(dst_idx), .src1_idx(src1_idx), .src2_idx(src2_idx));

  localparam int NV = 10;
  localparam logic [15:0] V_IR  [NV] = '{16'h14C4, 16'h12BF, 16'h12AF, 16'h14C4, 16'h5041,
                                         16'h5070, 16'h973F, 16'h7000, 16'h5020, 16'h101A};
  localparam logic [15:0] V_A   [NV] = '{16'h1234, 16'h0000, 16'h7FFF, 16'hFFFF, 16'hF0F0,
                                         16'hABCD, 16'h00FF, 16'hBEEF, 16'hFFFF, 16'h0001};
  localparam logic [15:0] V_B   [NV] = '{16'h0F0F, 16'h5555, 16'h1111, 16'h0001, 16'h3C3C,
                                         16'h0000, 16'hAAAA, 16'h1234, 16'hFFFF, 16'h0002};
  localparam logic [1:0]  V_F   [NV] = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b11,
                                         2'b11, 2'b10, 2'b01, 2'b11, 2'b00};
  localparam logic [15:0] V_EXP [NV] = '{16'h2143, 16'hFFFF, 16'h800E, 16'h0000, 16'h3030,
                                         16'hABC0, 16'hFF00, 16'hBEEF, 16'h0000, 16'h0003};

  function automatic logic [15:0] model(logic [15:0] ir, logic [15:0] a, logic [15:0] b,
                                        logic [1:0] f, logic en);
    logic [15:0] ob;
    ob = ir[5] ? {{11{ir[4]}}, ir[4:0]} : b;
    if (!en) return 16'h0;
    case (f)
      2'b00: return a + ob;
      2'b01: return a;
      2'b10: return ~a;
      default: return a & ob;
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] ir, logic [15:0] a, logic [15:0] b, logic [1:0] f, logic en);
    @(negedge clk);
    instr = ir; rd_a = a; rd_b = b; func = f; bus_en = en;
    #1;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    instr = 0; rd_a = 16'hFFFF; rd_b = 16'hFFFF; func = 2'b11; bus_en = 0;
    #2;
    chk("R8 idle at start", result, 16'h0);

    // vector table: R1 R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      apply(V_IR[i], V_A[i], V_B[i], V_F[i], 1'b1);
      chk($sformatf("R1/R2/R3/R4/R5/R6/R9 vec%0d", i), result, V_EXP[i]);
    end

    // random sweep over every function and both operand modes
    for (int i = 0; i < 400; i++) begin
      logic [15:0] ir, a, b;
      logic [1:0] f;
      ir = 16'($urandom); a = 16'($urandom); b = 16'($urandom); f = 2'(i % 4);
      ir[5] = i[2];
      apply(ir, a, b, f, 1'b1);
      chk(f == 2'b00 ? "R1 rand" : f == 2'b11 ? "R2 rand" : f == 2'b10 ? "R3 rand" : "R4 rand",
          result, model(ir, a, b, f, 1'b1));
    end

    // R3 and R4: operand B has no effect
    apply(16'h9A3F, 16'h1357, 16'h0000, 2'b10, 1'b1);
    chk("R3 b=0", result, 16'hECA8);
    apply(16'h9A3F, 16'h1357, 16'hFFFF, 2'b10, 1'b1);
    chk("R3 b=ffff", result, 16'hECA8);
    apply(16'h7000, 16'h2468, 16'hFFFF, 2'b01, 1'b1);
    chk("R4 store data", result, 16'h2468);

    // R5: rd_b ignored in immediate mode
    apply(16'h12BF, 16'h0010, 16'h7777, 2'b00, 1'b1);
    chk("R5 imm -1", result, 16'h000F);

    // R7 index fields: 1011 101 011 0 00 110 = 0xBAC6
    apply(16'hBAC6, 16'h0, 16'h0, 2'b00, 1'b1);
    chk("R7 dst", {13'h0, dst_idx}, 16'h5);
    chk("R7 src1", {13'h0, src1_idx}, 16'h3);
    chk("R7 src2", {13'h0, src2_idx}, 16'h6);

    // R8 enable gating
    apply(16'h14C4, 16'h1234, 16'h0F0F, 2'b00, 1'b0);
    chk("R8 disabled", result, 16'h0);
    apply(16'h14C4, 16'h1234, 16'h0F0F, 2'b00, 1'b1);
    chk("R8 enabled", result, 16'h2143);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule